// File: doc/BRIEF.md
# Address-Wake Serial Receiver

This block receives asynchronous serial frames and supports address/data framing for several stations sharing one line. Each frame carries a ninth bit after the eight data bits. When address/data framing is on, that bit tells an address frame (1) from a data frame (0). When the framing is off, the same bit slot can carry a parity bit, or it can be left out of the frame.

A wake latch lets a station sleep through traffic meant for others. While the latch is armed, data frames are dropped without a trace: no data, no completion flag, no error flags. The first address frame clears the latch, and that frame is then delivered normally. Software reads the byte and the received ninth bit together, decides whether the address is its own, and re-arms the latch if it is not.

The line is sampled on an oversampling tick that runs at 16 times the bit rate, and each bit is decided by a vote over three samples. All control fields are loaded together through a single write strobe.

Top module: `mpc_uart_rx`

## Requirements
- R1: After reset, `rx_done`, `rx_ovr`, `rx_ferr`, `rx_perr`, `rx_mpb`, `rx_data`, `wake_armed` and `mp_active` all read 0.
- R2: A frame has these parts in order: a low start bit, 8 data bits sent LSB first, an optional ninth bit, and a stop bit. Each bit lasts 16 ticks of `os_tick`. Each bit is the majority of the samples taken at ticks 7, 8 and 9 of its slot. A received frame loads `rx_data` and sets `rx_done`. A pulse on `rd_ack` clears `rx_done` and `rx_ovr`.
- R3: When address/data framing is active, the ninth bit is always present and is reported on `rx_mpb`. The parity settings have no effect, and `rx_perr` stays 0.
- R4: When address/data framing is inactive and parity is enabled, the ninth bit is the XOR of the data bits XOR `ctl_par_odd`, and a mismatch sets `rx_perr`. When parity is also disabled, the frame has no ninth bit and `rx_mpb` reads 0.
- R5: A frame whose ninth bit is 0 is discarded if it arrives while the wake latch is armed and framing is active. A discarded frame leaves `rx_data`, `rx_mpb`, `rx_done`, `rx_ovr`, `rx_ferr` and `rx_perr` unchanged.
- R6: A frame whose ninth bit is 1 arrives while the wake latch is armed and framing is active. Hardware clears the latch (`wake_armed` drops to 0), and the frame is received like any other.
- R7: While framing is inactive, the wake latch has no effect: frames are received, and `wake_armed` keeps the value that was written.
- R8: When `ctl_async` is 0, `mp_active` reads 0 whatever `ctl_mp_en` holds, and the receiver ignores the line.
- R9: A stop bit sampled low sets `rx_ferr` and still stores the data and sets `rx_done`. `rx_ferr` and `rx_perr` always describe the most recently received frame.
- R10: If a frame is received while `rx_done` is already set and no `rd_ack` arrives in that cycle, `rx_ovr` is set and the new data replaces the old.
- R11: In idle, a low pulse shorter than half a bit does not start a frame. A glitch that touches only one of the three samples in a bit does not change that bit.
- R12: Writing the wake latch while a frame is in progress takes effect for that frame, because each frame is judged at its stop-bit sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit |
| rxd | input | 1 | Serial receive line, idles high |
| ctl_we | input | 1 | Loads all control fields below |
| ctl_async | input | 1 | 1 selects asynchronous mode |
| ctl_mp_en | input | 1 | Address/data framing enable |
| ctl_wake | input | 1 | Wake latch value to write |
| ctl_par_en | input | 1 | Parity enable when framing is off |
| ctl_par_odd | input | 1 | 1 selects odd parity |
| rd_ack | input | 1 | Software has read the data |
| rx_data | output | 8 | Last received byte |
| rx_mpb | output | 1 | Ninth bit of last frame when framing is active |
| rx_done | output | 1 | Receive-complete flag |
| rx_ovr | output | 1 | Overrun flag |
| rx_ferr | output | 1 | Framing error of last frame |
| rx_perr | output | 1 | Parity error of last frame |
| wake_armed | output | 1 | Current wake latch state |
| mp_active | output | 1 | Address/data framing in effect |

## Verification
A frame's results appear in the outputs at a fixed point. The input synchronizer adds two clocks, the frame is judged at the stop-bit vote (tick 9 of the stop slot), and the status registers load one clock after that. So every status change lands well inside the stop bit. The bench drives each frame in full and then waits 40 idle clocks before it compares all outputs against its own model. That wait also covers the false start that follows a low stop bit. Control writes and `rd_ack` take effect on the next clock, and the bench samples them several clocks later on a falling edge.

// File: rtl/mpc_uart_pkg.sv
package mpc_uart_pkg;

  localparam int DW = 8;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          xbit;
    logic          stop;
  } rx_frame_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic par_bit(input logic [DW-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

endpackage

// File: rtl/mpc_rx_sync.sv
module mpc_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/mpc_rx_sampler.sv
module mpc_rx_sampler
  import mpc_uart_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      tick,
  input  logic      rxd,
  input  logic      xb_en,
  output logic      done_o,
  output rx_frame_t frame_o
);
  localparam int CW   = $clog2(OS_RATE);
  localparam int BW   = $clog2(DW + 2);
  localparam logic [CW-1:0] S_A  = CW'(OS_RATE/2 - 1);
  localparam logic [CW-1:0] S_B  = CW'(OS_RATE/2);
  localparam logic [CW-1:0] S_V  = CW'(OS_RATE/2 + 1);
  localparam logic [CW-1:0] LAST = CW'(OS_RATE - 1);

  rx_state_t     st;
  logic [CW-1:0] cnt;
  logic          s_a, s_b;
  logic [BW-1:0] bidx;
  logic [DW:0]   sh;
  logic          vote;
  logic [BW-1:0] last_bit;

  assign vote     = maj3(s_a, s_b, rxd);
  assign last_bit = xb_en ? BW'(DW) : BW'(DW - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RX_IDLE;
      cnt     <= '0;
      s_a     <= 1'b1;
      s_b     <= 1'b1;
      bidx    <= '0;
      sh      <= '0;
      done_o  <= 1'b0;
      frame_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!en) begin
        st <= RX_IDLE;
      end else if (tick) begin
        if (st != RX_IDLE) begin
          cnt <= cnt + 1'b1;
          if (cnt == S_A) s_a <= rxd;
          if (cnt == S_B) s_b <= rxd;
        end
        unique case (st)
          RX_IDLE: begin
            if (!rxd) begin
              st  <= RX_START;
              cnt <= '0;
            end
          end
          RX_START: begin
            if (cnt == S_V && vote) st <= RX_IDLE;
            else if (cnt == LAST) begin
              cnt  <= '0;
              bidx <= '0;
              st   <= RX_BITS;
            end
          end
          RX_BITS: begin
            if (cnt == S_V) sh <= {vote, sh[DW:1]};
            if (cnt == LAST) begin
              cnt <= '0;
              if (bidx == last_bit) st <= RX_STOP;
              else                  bidx <= bidx + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == S_V) begin
              done_o       <= 1'b1;
              frame_o.stop <= vote;
              frame_o.data <= xb_en ? sh[DW-1:0] : sh[DW:1];
              frame_o.xbit <= xb_en ? sh[DW] : 1'b0;
              st           <= RX_IDLE;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mpc_rx_gate.sv
module mpc_rx_gate
  import mpc_uart_pkg::*;
(
  input  logic      frm_done,
  input  rx_frame_t frame,
  input  logic      mp_active,
  input  logic      wake_q,
  input  logic      par_en,
  input  logic      par_odd,
  output logic      keep,
  output logic      wake_clr,
  output logic      perr_new,
  output logic      ferr_new
);
  logic armed;
  logic par_on;

  assign armed    = mp_active & wake_q;
  assign par_on   = ~mp_active & par_en;
  assign keep     = frm_done & ~(armed & ~frame.xbit);
  assign wake_clr = frm_done & armed & frame.xbit;
  assign perr_new = par_on & (frame.xbit != par_bit(frame.data, par_odd));
  assign ferr_new = ~frame.stop;
endmodule

// File: rtl/mpc_uart_rx.sv
module mpc_uart_rx
  import mpc_uart_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rxd,
  input  logic          ctl_we,
  input  logic          ctl_async,
  input  logic          ctl_mp_en,
  input  logic          ctl_wake,
  input  logic          ctl_par_en,
  input  logic          ctl_par_odd,
  input  logic          rd_ack,
  output logic [DW-1:0] rx_data,
  output logic          rx_mpb,
  output logic          rx_done,
  output logic          rx_ovr,
  output logic          rx_ferr,
  output logic          rx_perr,
  output logic          wake_armed,
  output logic          mp_active
);
  logic      async_q, mp_q, wake_q, par_en_q, par_odd_q;
  logic      rxd_s;
  logic      rx_en;
  logic      xb_en;
  logic      frm_done;
  rx_frame_t frm;
  logic      frm_xbit;
  logic      frm_keep, wake_clr, perr_new, ferr_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      async_q   <= 1'b0;
      mp_q      <= 1'b0;
      par_en_q  <= 1'b0;
      par_odd_q <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      if (ctl_we) begin
        async_q   <= ctl_async;
        mp_q      <= ctl_mp_en;
        par_en_q  <= ctl_par_en;
        par_odd_q <= ctl_par_odd;
        wake_q    <= ctl_wake;
      end else if (wake_clr) begin
        wake_q <= 1'b0;
      end
    end
  end

  assign rx_en     = async_q;
  assign mp_active = async_q & mp_q;
  assign xb_en     = mp_active | par_en_q;
  assign frm_xbit  = frm.xbit;

  mpc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
  );

  mpc_rx_sampler #(.OS_RATE(OS_RATE)) u_samp (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(os_tick), .rxd(rxd_s),
    .xb_en(xb_en), .done_o(frm_done), .frame_o(frm)
  );

  mpc_rx_gate u_gate (
    .frm_done(frm_done), .frame(frm), .mp_active(mp_active), .wake_q(wake_q),
    .par_en(par_en_q), .par_odd(par_odd_q), .keep(frm_keep),
    .wake_clr(wake_clr), .perr_new(perr_new), .ferr_new(ferr_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_mpb  <= 1'b0;
      rx_done <= 1'b0;
      rx_ovr  <= 1'b0;
      rx_ferr <= 1'b0;
      rx_perr <= 1'b0;
    end else if (frm_keep) begin
      rx_data <= frm.data;
      rx_mpb  <= mp_active & frm.xbit;
      rx_done <= 1'b1;
      rx_ovr  <= rx_done & ~rd_ack;
      rx_ferr <= ferr_new;
      rx_perr <= perr_new;
    end else if (rd_ack) begin
      rx_done <= 1'b0;
      rx_ovr  <= 1'b0;
    end
  end

  assign wake_armed = wake_q;
endmodule

// File: rtl/mpc_uart_rx_chk.sv
module mpc_uart_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frm_done,
  input logic       frm_keep,
  input logic       frm_xbit,
  input logic       wake_q,
  input logic       mp_active,
  input logic       rx_en,
  input logic       rd_ack,
  input logic       ctl_we,
  input logic [7:0] rx_data,
  input logic       rx_done,
  input logic       rx_ovr,
  input logic       rx_ferr,
  input logic       rx_perr
);
  assert_drop_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && !frm_keep && !rd_ack) |=>
      ($stable(rx_done) && $stable(rx_data) && $stable(rx_ovr) && $stable(rx_ferr) && $stable(rx_perr)));

  assert_addr_wakes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && mp_active && wake_q && frm_xbit && !ctl_we) |=> (!wake_q && rx_done));

  assert_idle_when_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !frm_done);

  assert_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_keep && rx_done && !rd_ack) |=> rx_ovr);

  assert_ack_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !frm_keep) |=> (!rx_done && !rx_ovr));

  assert_no_parity_in_mp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_keep && mp_active) |=> !rx_perr);
endmodule

bind mpc_uart_rx mpc_uart_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_keep(frm_keep),
  .frm_xbit(frm_xbit), .wake_q(wake_q), .mp_active(mp_active), .rx_en(rx_en),
  .rd_ack(rd_ack), .ctl_we(ctl_we), .rx_data(rx_data), .rx_done(rx_done),
  .rx_ovr(rx_ovr), .rx_ferr(rx_ferr), .rx_perr(rx_perr)
);

// File: tb/mpc_uart_rx_bench.sv
module mpc_uart_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CYC    = 32;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ph = 1'b0;
  logic rxd = 1'b1;
  logic ctl_we = 1'b0, ctl_async = 1'b0, ctl_mp_en = 1'b0, ctl_wake = 1'b0;
  logic ctl_par_en = 1'b0, ctl_par_odd = 1'b0, rd_ack = 1'b0;
  logic [7:0] rx_data;
  logic rx_mpb, rx_done, rx_ovr, rx_ferr, rx_perr, wake_armed, mp_active;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tick_ph <= ~tick_ph;

  mpc_uart_rx u_mpc_uart_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(tick_ph), .rxd(rxd),
    .ctl_we(ctl_we), .ctl_async(ctl_async), .ctl_mp_en(ctl_mp_en),
    .ctl_wake(ctl_wake), .ctl_par_en(ctl_par_en), .ctl_par_odd(ctl_par_odd),
    .rd_ack(rd_ack), .rx_data(rx_data), .rx_mpb(rx_mpb), .rx_done(rx_done),
    .rx_ovr(rx_ovr), .rx_ferr(rx_ferr), .rx_perr(rx_perr),
    .wake_armed(wake_armed), .mp_active(mp_active)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  // bench model state
  bit m_async, m_mp, m_wake, m_pe, m_po;
  logic [7:0] e_data = 8'h00;
  bit e_mpb, e_done, e_ovr, e_ferr, e_perr;

  function automatic bit exp_par(input logic [7:0] d, input bit odd);
    bit p = odd;
    for (int i = 0; i < 8; i++) p = p ^ d[i];
    return p;
  endfunction

  function automatic bit mp_on();
    return m_async && m_mp;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    chk({req, " data"}, rx_data, e_data);
    chk({req, " mpb"},  rx_mpb,  e_mpb);
    chk({req, " done"}, rx_done, e_done);
    chk({req, " ovr"},  rx_ovr,  e_ovr);
    chk({req, " ferr"}, rx_ferr, e_ferr);
    chk({req, " perr"}, rx_perr, e_perr);
    chk({req, " wake"}, wake_armed, m_wake);
    chk({req, " mpact"}, mp_active, mp_on());
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(input bit a, input bit mp, input bit wk, input bit pe, input bit po);
    @(negedge clk);
    ctl_we = 1; ctl_async = a; ctl_mp_en = mp; ctl_wake = wk;
    ctl_par_en = pe; ctl_par_odd = po;
    @(negedge clk);
    ctl_we = 0;
    m_async = a; m_mp = mp; m_wake = wk; m_pe = pe; m_po = po;
  endtask

  task automatic read_ack();
    @(negedge clk);
    rd_ack = 1;
    @(negedge clk);
    rd_ack = 0;
    e_done = 0; e_ovr = 0;
  endtask

  task automatic drive_bit(input bit v, input bit glitch);
    for (int c = 0; c < BIT_CYC; c++) begin
      @(negedge clk);
      rxd = (glitch && (c == 15 || c == 16)) ? ~v : v;
    end
  endtask

  // Sends one frame on the line; the ninth bit is sent when the bench
  // configuration says it is part of the frame.
  task automatic send_raw(input logic [7:0] d, input bit xb, input bit stop, input int gbit);
    bit has_x = mp_on() || m_pe;
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i], gbit == i);
    if (has_x) drive_bit(xb, 1'b0);
    drive_bit(stop, 1'b0);
    @(negedge clk);
    rxd = 1'b1;
    idle(40);
  endtask

  task automatic model_frame(input logic [7:0] d, input bit xb, input bit stop, input bit rd_same);
    bit has_x = mp_on() || m_pe;
    bit xv = has_x ? xb : 1'b0;
    if (!m_async) return;
    if (mp_on() && m_wake && !xv) return;
    if (mp_on() && m_wake && xv) m_wake = 0;
    e_ovr  = e_done && !rd_same;
    e_done = 1;
    e_data = d;
    e_mpb  = mp_on() ? xv : 1'b0;
    e_ferr = !stop;
    e_perr = !mp_on() && m_pe && (xv != exp_par(d, m_po));
  endtask

  task automatic frame(input logic [7:0] d, input bit xb, input bit stop, input string req);
    model_frame(d, xb, stop, 1'b0);
    send_raw(d, xb, stop, -1);
    compare_all(req);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    idle(4);
    rst_n = 1'b1;
    idle(2);
    compare_all("R1 reset");

    // R8: synchronous mode selected, framing forced off, line ignored
    ctl_write(0, 1, 0, 0, 0);
    chk("R8 mp forced off", mp_active, 0);
    frame(8'h5A, 1, 1, "R8 ignored");

    // R2 / R4 plain 10-bit frame, then ack
    ctl_write(1, 0, 0, 0, 0);
    frame(8'hA5, 0, 1, "R2 plain");
    read_ack();
    idle(3);
    compare_all("R2 ack");

    // R4 parity even ok, then odd mismatch
    ctl_write(1, 0, 0, 1, 0);
    frame(8'h37, exp_par(8'h37, 0), 1, "R4 even ok");
    read_ack();
    ctl_write(1, 0, 0, 1, 1);
    frame(8'h37, exp_par(8'h37, 0), 1, "R4 odd bad");
    read_ack();

    // R3 framing on, parity settings ignored, ninth bit reported
    ctl_write(1, 1, 0, 1, 1);
    frame(8'h12, 1, 1, "R3 addr");
    read_ack();
    frame(8'h34, 0, 1, "R3 data");

    // R10 overrun: done still set
    frame(8'h99, 0, 1, "R10 overrun");
    read_ack();

    // R5 armed drop, even with bad stop
    ctl_write(1, 1, 1, 0, 0);
    frame(8'hC3, 0, 1, "R5 drop");
    frame(8'h3C, 0, 0, "R5 drop ferr");
    // R6 address wakes
    frame(8'h07, 1, 1, "R6 wake");
    read_ack();

    // R9 framing error, data kept
    frame(8'hE1, 0, 0, "R9 ferr");
    frame(8'h1E, 0, 1, "R9 ferr cleared");
    read_ack();

    // R7 wake ignored when framing off
    ctl_write(1, 0, 1, 0, 0);
    frame(8'h66, 0, 1, "R7 received");
    read_ack();

    // R11 false start and glitch
    ctl_write(1, 0, 0, 0, 0);
    @(negedge clk); rxd = 0;
    idle(4);
    rxd = 1;
    idle(80);
    compare_all("R11 false start");
    model_frame(8'hB4, 0, 1, 1'b0);
    send_raw(8'hB4, 0, 1, 3);
    compare_all("R11 glitch");
    read_ack();

    // R12 wake written mid-frame
    ctl_write(1, 1, 0, 0, 0);
    fork
      send_raw(8'h81, 0, 1, -1);
      begin
        idle(BIT_CYC * 3);
        ctl_write(1, 1, 1, 0, 0);
      end
    join
    compare_all("R12 mid-frame arm");

    // random mix
    for (int n = 0; n < 36; n++) begin
      logic [7:0] d = 8'($urandom);
      bit xb = 1'($urandom);
      bit st = ($urandom % 8) != 0;
      if (n % 5 == 0)
        ctl_write(($urandom % 6) != 0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      frame(d, xb, st, "R2 random");
      if ($urandom % 2 == 1) read_ack();
    end

    finish_run();
  end
endmodule